// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit configuration registers and presents them on a parallel bus to the logic around it. The slave answers to one fixed 7-bit device address, 0x69. The host sends 0xD2 to write and 0xD3 to read.

A write carries two leading bytes, a command code and a byte count. Both must be present, both are acknowledged, and neither has any effect. The data bytes that follow always fill the registers from register 0 upward. The host may end the transfer with a stop condition after any complete byte.

A read returns a count byte first and then every register in index order. The host acknowledges each byte and ends the read with a not-acknowledge. Both bus lines are sampled with the core clock, which must run many times faster than the serial bit rate. Standard mode, up to 100 kbit/s, is the intended rate. Each line passes through a two-flop synchroniser and a three-sample majority-free filter, in which all three samples must agree.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00, registers 1 to 5 hold 0xFF (cfg_q bits [8k+7:8k] are register k), and sda_oe is low.
- R2: Address bytes 0xD2 and 0xD3 are acknowledged. Any other address byte gets no acknowledge, and the rest of that transfer has no effect on the registers.
- R3: In a write, the first two bytes after the address are acknowledged and leave every register unchanged.
- R4: From the third byte after the address onward, each byte is acknowledged and stored, MSB first, into registers 0, 1, 2 and so on in order.
- R5: A stop after any complete byte ends the write. Bytes already received stay stored, and registers not reached keep their values.
- R6: Data bytes that arrive after register 5 has been written are acknowledged and discarded.
- R7: A data byte cut short by a stop before its eighth bit is not stored.
- R8: A read first returns the byte count 6, then registers 0 to 5, each MSB first.
- R9: A host not-acknowledge ends a read. The slave releases SDA, and a following write is handled normally.
- R10: An SDA pulse lasting fewer than three core-clock samples while SCL is high is not taken as a start or a stop condition.
- R11: sda_oe (1 = pull SDA low) is asserted only in an acknowledge slot or while a read byte is being sent, never while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock used to oversample both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_q | output | 48 | Register contents, register k on bits [8k+7:8k] |

## Verification
The assertions assume that SDA changes only while SCL is low, except where the host deliberately forms a start or a stop. They also assume that every SCL level lasts far longer than the filter and synchroniser latency. The bench keeps each SCL phase at ten core-clock cycles or more, and it moves SDA two cycles after the falling edge of SCL. That way the filtered SDA never changes in the same cycle as the filtered SCL. The one deliberate exception is a two-cycle SDA pulse injected during an SCL-high phase, which stays below the three-sample filter window.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the serial configuration slave.
package cfg_i2c_pkg;
    typedef logic [7:0] byte_t;

    // Link layer state of the serial slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_t;
endpackage

// File: rtl/cfg_i2c_line_filter.sv
// Synchronises one open-drain bus line into the core clock and removes
// pulses shorter than FILT_LEN samples. Assumes the line idles high, so
// every stage resets to 1.
module cfg_i2c_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q
);
    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Synchroniser chain, history window and filtered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], line_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            if (&hist_q)
                line_q <= 1'b1;
            else if (~|hist_q)
                line_q <= 1'b0;
        end
    end

    // R10: the filtered line moves only after a full window of agreeing samples
    a_r10_filter_window: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q != $past(line_q)) |-> ($past(hist_q) == {FILT_LEN{line_q}}));
endmodule

// File: rtl/cfg_i2c_regbank.sv
// Configuration register bank: NREG bytes with per-register reset
// defaults and one byte write port. Assumes wr_idx is below NREG when
// wr_en is set.
module cfg_i2c_regbank #(
    parameter int NREG = 6,
    parameter int IDX_W = 4,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] regs_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One register: reset default, replaced when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g*8 +: 8] <= DEFAULTS[g*8 +: 8];
            else if (wr_en && wr_idx == IDX_W'(g))
                regs_q[g*8 +: 8] <= wr_data;
        end
    end

    // R1: reset loads the defaults
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (regs_q == DEFAULTS));
    // R3: the bank changes only after a write strobe
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/cfg_i2c_link.sv
// Byte-level slave protocol engine. Detects start and stop on the
// filtered lines, shifts bytes in and out, drives acknowledges, and
// issues one register write for each complete data byte. Assumes the
// filtered SDA never changes in the same cycle as the filtered SCL,
// except at start and stop conditions.
module cfg_i2c_link
    import cfg_i2c_pkg::*;
#(
    parameter int NREG = 6,
    parameter int CNT_W = 4,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [NREG*8-1:0] rd_bus,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [CNT_W-1:0]  wr_idx,
    output byte_t             wr_data
);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(NREG + 2);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(NREG);
    localparam byte_t            COUNT_BYTE = 8'(NREG);

    link_state_t      state;
    logic             scl_d, sda_d;
    logic             is_addr, rd_mode;
    logic [3:0]       bit_cnt;
    byte_t            shreg, tx_sr, tx_next, rx_byte;
    logic [CNT_W-1:0] byte_cnt, tx_idx;
    logic             start_c, stop_c, scl_rise, scl_fall;

    assign start_c  = scl_f && scl_d && sda_d && !sda_f;
    assign stop_c   = scl_f && scl_d && !sda_d && sda_f;
    assign scl_rise = scl_f && !scl_d;
    assign scl_fall = !scl_f && scl_d;
    assign rx_byte  = {shreg[6:0], sda_f};

    // Previous filtered line levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Next byte to transmit: count byte, then registers, then all ones
    always_comb begin
        int sel;
        sel = int'(tx_idx) - 1;
        if (tx_idx == '0)
            tx_next = COUNT_BYTE;
        else if (tx_idx <= CNT_LAST)
            tx_next = rd_bus[sel*8 +: 8];
        else
            tx_next = 8'hFF;
    end

    // Protocol state machine, shifters and write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            is_addr  <= 1'b0;
            rd_mode  <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx_sr    <= '1;
            byte_cnt <= '0;
            tx_idx   <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                state    <= ST_RX;
                is_addr  <= 1'b1;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                tx_idx   <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                if (is_addr) begin
                                    if (rx_byte[7:1] != DEV_ADDR)
                                        state <= ST_IDLE;
                                    else
                                        rd_mode <= rx_byte[0];
                                end else begin
                                    if (byte_cnt >= CNT_FIRST && byte_cnt < CNT_END) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= byte_cnt - CNT_FIRST;
                                        wr_data <= rx_byte;
                                    end
                                    if (byte_cnt != '1)
                                        byte_cnt <= byte_cnt + 1'b1;
                                end
                            end
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state   <= ST_RX_ACK;
                            sda_oe  <= 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            is_addr <= 1'b0;
                            bit_cnt <= '0;
                            if (rd_mode && is_addr) begin
                                state  <= ST_TX;
                                tx_sr  <= tx_next;
                                sda_oe <= ~tx_next[7];
                                if (tx_idx != '1)
                                    tx_idx <= tx_idx + 1'b1;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                state  <= ST_TX_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sr  <= {tx_sr[6:0], 1'b1};
                                sda_oe <= ~tx_sr[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && sda_f) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            state   <= ST_TX;
                            bit_cnt <= '0;
                            tx_sr   <= tx_next;
                            sda_oe  <= ~tx_next[7];
                            if (tx_idx != '1)
                                tx_idx <= tx_idx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the slave never pulls SDA while idle
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    // R6: write strobes only target existing registers
    a_r6_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < CNT_LAST));
    // R3: no write strobe before the two discarded bytes have passed
    a_r3_skip_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (byte_cnt > CNT_FIRST));
    // R9: a host not-acknowledge during a read drops the slave to idle
    a_r9_nak_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_rise && sda_f && !start_c && !stop_c) |=> (state == ST_IDLE));
endmodule

// File: rtl/cfg_i2c_slave.sv
// Top level of the serial configuration slave: line filters, protocol
// engine and register bank. Assumes clk oversamples SCL by well over
// ten cycles per SCL phase.
module cfg_i2c_slave #(
    parameter int NREG = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter logic [NREG*8-1:0] DEFAULTS = 48'hFFFF_FFFF_FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_q
);
    localparam int CNT_W = $clog2(NREG + 3);

    logic             scl_f, sda_f, wr_en;
    logic [CNT_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    cfg_i2c_line_filter #(.SYNC_LEN(2), .FILT_LEN(3)) i_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(scl_f)
    );
    cfg_i2c_line_filter #(.SYNC_LEN(2), .FILT_LEN(3)) i_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_q(sda_f)
    );

    cfg_i2c_link #(.NREG(NREG), .CNT_W(CNT_W), .DEV_ADDR(DEV_ADDR)) i_link (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .rd_bus(cfg_q), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cfg_i2c_regbank #(.NREG(NREG), .IDX_W(CNT_W), .DEFAULTS(DEFAULTS)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_q(cfg_q)
    );
endmodule

// File: tb/test_cfg_i2c_slave.sv
// Bench: a bus host model drives write and read transfers, and a
// register model predicts cfg_q and the bytes read back.
module test_cfg_i2c_slave;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [47:0] cfg_q;
    wire         sda_line = sda_m & ~sda_oe;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [7:0]  mdl [6];
    logic [7:0]  rd_buf [8];

    always #2.5 clk = ~clk;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .cfg_q(cfg_q)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL period; optional short SDA pulse while SCL is high
    task automatic bus_bit(input bit b, input bit glitch, output bit r);
        wait_n(2);
        sda_m = b;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(4);
        if (glitch) begin
            sda_m = ~b;
            wait_n(2);
            sda_m = b;
        end
        wait_n(glitch ? Q - 6 : Q - 4);
        r = sda_line;
        wait_n(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(2);
        sda_m = 1'b1;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(Q);
        sda_m = 1'b0;
        wait_n(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(2);
        sda_m = 1'b0;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(Q);
        sda_m = 1'b1;
        wait_n(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], (i == glitch_bit), r);
        bus_bit(1'b1, 1'b0, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, 1'b0, r);
            d[i] = r;
        end
        bus_bit(!give_ack, 1'b0, r);
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 71 + 5) & 255);
    endfunction

    // Full write transfer: address, command, count, nb data bytes
    task automatic wr_txn(input logic [7:0] addr, input int nb, input int seed, output int acks);
        bit a;
        acks = 0;
        bus_start();
        send_byte(addr, -1, a); acks += int'(a);
        send_byte(8'h5A, -1, a); acks += int'(a);
        send_byte(8'hA5, -1, a); acks += int'(a);
        for (int i = 0; i < nb; i++) begin
            send_byte(pat(seed, i), -1, a);
            acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input int nb, output bit addr_ack);
        bit a;
        bus_start();
        send_byte(8'hD3, -1, a);
        addr_ack = a;
        for (int i = 0; i < nb; i++) recv_byte(i != nb - 1, rd_buf[i]);
        bus_stop();
    endtask

    task automatic chk_regs(input string req);
        for (int k = 0; k < 6; k++)
            chk(cfg_q[k*8 +: 8] === mdl[k], req, 64'(cfg_q[k*8 +: 8]), 64'(mdl[k]));
    endtask

    task automatic chk_readback(input string req);
        bit a;
        rd_txn(7, a);
        chk(a, {req, " addr ack"}, 64'(a), 64'd1);
        chk(rd_buf[0] === 8'd6, {req, " count"}, 64'(rd_buf[0]), 64'd6);
        for (int k = 0; k < 6; k++)
            chk(rd_buf[k+1] === mdl[k], req, 64'(rd_buf[k+1]), 64'(mdl[k]));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        int acks;
        bit a;
        bit r;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // R1: reset state
        mdl[0] = 8'h00;
        for (int k = 1; k < 6; k++) mdl[k] = 8'hFF;
        chk_regs("R1 reset");
        chk(sda_oe === 1'b0, "R1 sda_oe", 64'(sda_oe), 64'd0);

        // R3 R5: header-only write changes nothing
        wr_txn(8'hD2, 0, 1, acks);
        chk(acks == 3, "R3 header acks", 64'(acks), 64'd3);
        wait_n(20);
        chk_regs("R3 header only");

        // R4 R5 R6 R8: sweep the number of data bytes 1..9
        for (int nb = 1; nb <= 9; nb++) begin
            wr_txn(8'hD2, nb, nb, acks);
            chk(acks == 3 + nb, "R4 R6 data acks", 64'(acks), 64'(3 + nb));
            for (int i = 0; i < nb && i < 6; i++) mdl[i] = pat(nb, i);
            wait_n(20);
            chk_regs("R4 R5 R6 write sweep");
            chk_readback("R8 readback");
        end

        // R2: wrong address, no ack, no effect
        wr_txn(8'hA0, 4, 77, acks);
        chk(acks == 0, "R2 foreign address", 64'(acks), 64'd0);
        wait_n(20);
        chk_regs("R2 no effect");

        // R7: second data byte aborted after four bits
        bus_start();
        send_byte(8'hD2, -1, a);
        chk(a, "R2 write address ack", 64'(a), 64'd1);
        send_byte(8'h00, -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'h3C, -1, a);
        mdl[0] = 8'h3C;
        for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, r);
        bus_stop();
        wait_n(20);
        chk_regs("R7 partial byte dropped");

        // R10: glitch on a zero bit while SCL is high
        bus_start();
        send_byte(8'hD2, -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'h81, 3, a);
        chk(a, "R10 ack after glitch", 64'(a), 64'd1);
        send_byte(8'h42, -1, a);
        bus_stop();
        mdl[0] = 8'h81;
        mdl[1] = 8'h42;
        wait_n(20);
        chk_regs("R10 glitch ignored");

        // R9 R11: short read ended by NAK, then a write
        rd_txn(2, a);
        chk(rd_buf[0] === 8'd6 && rd_buf[1] === mdl[0], "R9 short read",
            64'({rd_buf[0], rd_buf[1]}), 64'({8'd6, mdl[0]}));
        wait_n(5);
        chk(sda_oe === 1'b0, "R9 R11 released", 64'(sda_oe), 64'd0);
        wr_txn(8'hD2, 2, 200, acks);
        mdl[0] = pat(200, 0);
        mdl[1] = pat(200, 1);
        chk(acks == 5, "R9 write after read", 64'(acks), 64'd5);
        wait_n(20);
        chk_regs("R9 write after read");

        done = 1'b1;
        finish_run();
    end
endmodule